// File: doc/BRIEF.md
# Command FIFO Front End with Threshold Events

This block sits between a host register port and the byte engine of a serial bus master. The host queues 11-bit command words by writing the data/command register. The engine drains them through a valid/ready handshake. Bytes the engine receives come back through a receive FIFO, and the host collects them by reading that same register. Both FIFOs have level registers, and each has a programmable threshold that drives a level-sensitive event output. Overflow and underflow conditions raise one-cycle event pulses. An abort from the engine empties both queues in a single cycle.

An enable register gates the engine. The enable-status register does not follow a write at once: it takes the enable value only on a cycle in which the engine reports that it is idle. Software writes the enable bit and then polls the status copy to learn when the change has taken effect. A bus status register reports whether the engine is active and gives a coarse view of the FIFOs.

Top module: `cmdq_frontend`

## Requirements
- R1: A write to address 0 pushes `reg_wdata` as a command word. The engine receives the words in push order on `cmd_word`, with bits 7:0 as write data, bit 8 as the read request, bit 9 as stop-after and bit 10 as restart-before. `cmd_valid` is high whenever the transmit FIFO holds a word, and each cycle with `cmd_ready` high consumes one word.
- R2: Reads of address 6 return the transmit fill count, and reads of address 7 return the receive fill count. Each count is updated in the cycle that follows a push or a pop.
- R3: `tx_thr_evt` is high while the transmit level is less than or equal to the value written to address 1.
- R4: `rx_thr_evt` is high while the receive level is strictly greater than the value written to address 2, so a threshold of 0 fires on one byte.
- R5: A cycle with `eng_abort` high leaves both FIFO levels at zero, and any push or pop in that same cycle is discarded.
- R6: Address 3 holds the enable request, which drives `eng_enable`. Address 4 bit 0 copies that request only on cycles in which `eng_idle` is high, and otherwise holds its value.
- R7: Address 5 returns `eng_active` in bit 0, "transmit FIFO full" in bit 1 and "receive FIFO not empty" in bit 2.
- R8: A push into a full transmit FIFO is dropped, the level stays at the depth, and `tx_ovf` pulses for one cycle.
- R9: A read of address 0 while the receive FIFO is empty returns zero, leaves the level at zero, and pulses `rx_unf` for one cycle.
- R10: An `rx_push` into a full receive FIFO drops the byte, the level stays at the depth, and `rx_ovf` pulses for one cycle.
- R11: After reset both levels, both thresholds, the enable request and the enable status are zero, and `cmd_valid` is low.
- R12: Reads of address 0 return the received bytes in arrival order, in bits 7:0 with the upper bits zero, and each read pops one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 0) |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 11 | Read data, combinational from `reg_addr` |
| cmd_valid | output | 1 | Transmit FIFO holds a command |
| cmd_word | output | 11 | Head command word |
| cmd_ready | input | 1 | Engine consumes the head command |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| eng_abort | input | 1 | Transfer abort, flushes both FIFOs |
| eng_idle | input | 1 | Engine at an idle point |
| eng_active | input | 1 | Bus activity indication |
| eng_enable | output | 1 | Enable request to the engine |
| tx_thr_evt | output | 1 | Transmit level at or below threshold |
| rx_thr_evt | output | 1 | Receive level above threshold |
| tx_ovf | output | 1 | Pulse: dropped command push |
| rx_ovf | output | 1 | Pulse: dropped received byte |
| rx_unf | output | 1 | Pulse: read of empty receive FIFO |

## Verification
The checks embedded in the RTL assume that the engine raises `cmd_ready` only while `cmd_valid` is high, so the transmit queue is never popped when it is empty. The stimulus keeps to this assumption by sampling `cmd_valid` before each consume. Every other input is assumed to change only away from the rising edge. The bench meets this by driving all strobes on the falling edge and holding each one for exactly one cycle. The abort, overflow and enable scenarios fill the queues through the same ports that software and the engine would use.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
   typedef enum logic [2:0] {
      A_DATA    = 3'd0,
      A_TX_THR  = 3'd1,
      A_RX_THR  = 3'd2,
      A_ENABLE  = 3'd3,
      A_EN_STAT = 3'd4,
      A_BUS_ST  = 3'd5,
      A_TX_LVL  = 3'd6,
      A_RX_LVL  = 3'd7
   } reg_sel_e;

   localparam int FLAG_READ    = 8;
   localparam int FLAG_STOP    = 9;
   localparam int FLAG_RESTART = 10;
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty,
   output logic          ovf,
   output logic          unf
);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cmdq_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("cmdq_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          do_push, do_pop;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_mod
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else begin
         ovf <= push && full && !flush;
         unf <= pop && empty && !flush;
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
         end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            level <= level + LW'(do_push) - LW'(do_pop);
         end
      end
   end

   // R2
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH));

   // R5
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));

   // R8 R10
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (level == LW'(DEPTH)));

   // R9
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> (level == '0));
endmodule

// File: rtl/cmdq_enable_ctl.sv
module cmdq_enable_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_val,
   input  logic eng_idle,
   output logic en_req,
   output logic en_stat
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_req  <= 1'b0;
         en_stat <= 1'b0;
      end else begin
         if (wr_en) en_req <= wr_val;
         if (eng_idle) en_stat <= en_req;
      end
   end

   // R6
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_idle |=> $stable(en_stat));

   // R6
   en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_idle && !wr_en) |=> (en_stat == en_req));
endmodule

// File: rtl/cmdq_frontend.sv
module cmdq_frontend #(
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8,
   parameter int BYTE_W   = 8,
   localparam int CMD_W   = BYTE_W + 3,
   localparam int TX_LW   = $clog2(TX_DEPTH + 1),
   localparam int RX_LW   = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [CMD_W-1:0]  reg_wdata,
   output logic [CMD_W-1:0]  reg_rdata,
   output logic              cmd_valid,
   output logic [CMD_W-1:0]  cmd_word,
   input  logic              cmd_ready,
   input  logic              rx_push,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              eng_abort,
   input  logic              eng_idle,
   input  logic              eng_active,
   output logic              eng_enable,
   output logic              tx_thr_evt,
   output logic              rx_thr_evt,
   output logic              tx_ovf,
   output logic              rx_ovf,
   output logic              rx_unf
);
   import cmdq_pkg::*;

   generate
      if (CMD_W < TX_LW || CMD_W < RX_LW) begin : g_bad_widths
         $error("cmdq_frontend: level does not fit the register width");
      end
      if (CMD_W != FLAG_RESTART + 1) begin : g_bad_flags
         $error("cmdq_frontend: command flags need an 8-bit byte");
      end
   endgenerate

   reg_sel_e          sel;
   logic              tx_push, rx_pop;
   logic [TX_LW-1:0]  tx_lvl, tx_thr;
   logic [RX_LW-1:0]  rx_lvl, rx_thr;
   logic [BYTE_W-1:0] rx_head;
   logic              tx_full, tx_empty, tx_unf;
   logic              rx_full, rx_empty;
   logic              en_req, en_stat;

   assign sel     = reg_sel_e'(reg_addr);
   assign tx_push = reg_wr && (sel == A_DATA);
   assign rx_pop  = reg_rd && (sel == A_DATA);

   cmdq_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(eng_abort),
      .push(tx_push), .din(reg_wdata), .pop(cmd_ready),
      .dout(cmd_word), .level(tx_lvl), .full(tx_full), .empty(tx_empty),
      .ovf(tx_ovf), .unf(tx_unf)
   );

   cmdq_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(eng_abort),
      .push(rx_push), .din(rx_byte), .pop(rx_pop),
      .dout(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty),
      .ovf(rx_ovf), .unf(rx_unf)
   );

   cmdq_enable_ctl u_en (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr && (sel == A_ENABLE)), .wr_val(reg_wdata[0]),
      .eng_idle(eng_idle), .en_req(en_req), .en_stat(en_stat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_thr <= '0;
         rx_thr <= '0;
      end else if (reg_wr) begin
         if (sel == A_TX_THR) tx_thr <= reg_wdata[TX_LW-1:0];
         if (sel == A_RX_THR) rx_thr <= reg_wdata[RX_LW-1:0];
      end
   end

   assign cmd_valid  = !tx_empty;
   assign eng_enable = en_req;
   assign tx_thr_evt = (tx_lvl <= tx_thr);
   assign rx_thr_evt = (rx_lvl > rx_thr);

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         A_DATA:    reg_rdata = rx_empty ? '0 : CMD_W'(rx_head);
         A_TX_THR:  reg_rdata = CMD_W'(tx_thr);
         A_RX_THR:  reg_rdata = CMD_W'(rx_thr);
         A_ENABLE:  reg_rdata = CMD_W'(en_req);
         A_EN_STAT: reg_rdata = CMD_W'(en_stat);
         A_BUS_ST:  reg_rdata = CMD_W'({!rx_empty, tx_full, eng_active});
         A_TX_LVL:  reg_rdata = CMD_W'(tx_lvl);
         A_RX_LVL:  reg_rdata = CMD_W'(rx_lvl);
         default:   reg_rdata = '0;
      endcase
   end

   // R1: engine handshake assumption, never consumes from an empty queue
   engine_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_unf);

   // R11
   reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !cmd_valid);
endmodule

// File: tb/cmdq_frontend_tb.sv
module cmdq_frontend_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [10:0] reg_wdata = '0;
   logic [10:0] reg_rdata;
   logic        cmd_valid, cmd_ready = 1'b0;
   logic [10:0] cmd_word;
   logic        rx_push = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        eng_abort = 1'b0, eng_idle = 1'b1, eng_active = 1'b0;
   logic        eng_enable, tx_thr_evt, rx_thr_evt, tx_ovf, rx_ovf, rx_unf;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cmdq_frontend u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
      .rx_push(rx_push), .rx_byte(rx_byte), .eng_abort(eng_abort),
      .eng_idle(eng_idle), .eng_active(eng_active), .eng_enable(eng_enable),
      .tx_thr_evt(tx_thr_evt), .rx_thr_evt(rx_thr_evt), .tx_ovf(tx_ovf),
      .rx_ovf(rx_ovf), .rx_unf(rx_unf)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [10:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [10:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic eng_take(input logic [10:0] exp, input string req);
      @(negedge clk);
      check({req, " cmd_valid"}, cmd_valid, 1);
      check({req, " cmd_word"}, cmd_word, exp);
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
   endtask

   task automatic eng_give(input logic [7:0] b);
      @(negedge clk);
      rx_push = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic t_reset;
      logic [10:0] d;
      reg_read(3'd6, d); check("R11 tx level", d, 0);
      reg_read(3'd7, d); check("R11 rx level", d, 0);
      reg_read(3'd1, d); check("R11 tx thr", d, 0);
      reg_read(3'd2, d); check("R11 rx thr", d, 0);
      reg_read(3'd3, d); check("R11 enable", d, 0);
      reg_read(3'd4, d); check("R11 en status", d, 0);
      check("R11 cmd_valid", cmd_valid, 0);
      check("R3 evt at level 0 thr 0", tx_thr_evt, 1);
   endtask

   task automatic t_cmd_order;
      logic [10:0] d;
      reg_write(3'd0, 11'h05A);
      reg_write(3'd0, 11'h100);
      reg_write(3'd0, 11'h6C3);
      reg_read(3'd6, d); check("R2 tx level 3", d, 3);
      eng_take(11'h05A, "R1 plain write");
      eng_take(11'h100, "R1 read flag");
      eng_take(11'h6C3, "R1 stop+restart");
      check("R1 drained", cmd_valid, 0);
   endtask

   task automatic t_tx_thr;
      reg_write(3'd1, 11'd2);
      for (int i = 0; i < 3; i++) reg_write(3'd0, 11'(i));
      check("R3 level 3 > thr 2", tx_thr_evt, 0);
      eng_take(11'd0, "R3");
      check("R3 level 2 <= thr 2", tx_thr_evt, 1);
      eng_take(11'd1, "R3");
      eng_take(11'd2, "R3");
   endtask

   task automatic t_rx_thr;
      logic [10:0] d;
      reg_write(3'd2, 11'd0);
      eng_give(8'h11);
      check("R4 one byte thr 0", rx_thr_evt, 1);
      reg_write(3'd2, 11'd1);
      check("R4 one byte thr 1", rx_thr_evt, 0);
      eng_give(8'h22);
      check("R4 two bytes thr 1", rx_thr_evt, 1);
      reg_read(3'd7, d); check("R2 rx level 2", d, 2);
      reg_read(3'd0, d); check("R12 first byte", d, 11'h011);
      reg_read(3'd0, d); check("R12 second byte", d, 11'h022);
      reg_read(3'd7, d); check("R2 rx level 0", d, 0);
   endtask

   task automatic t_underflow;
      logic [10:0] d;
      reg_read(3'd0, d);
      check("R9 empty read data", d, 0);
      check("R9 rx_unf pulse", rx_unf, 1);
      @(negedge clk);
      check("R9 rx_unf one cycle", rx_unf, 0);
      reg_read(3'd7, d); check("R9 level stays 0", d, 0);
   endtask

   task automatic t_overflows;
      logic [10:0] d;
      for (int i = 0; i < 8; i++) reg_write(3'd0, 11'(8'hA0 + i));
      check("R8 no ovf while filling", tx_ovf, 0);
      reg_write(3'd0, 11'h7FF);
      check("R8 tx_ovf pulse", tx_ovf, 1);
      reg_read(3'd6, d); check("R8 tx level at depth", d, 8);
      reg_read(3'd5, d); check("R7 tx full bit", d[1], 1);
      for (int i = 0; i < 8; i++) eng_give(8'(8'h30 + i));
      eng_give(8'hEE);
      check("R10 rx_ovf pulse", rx_ovf, 1);
      reg_read(3'd7, d); check("R10 rx level at depth", d, 8);
      eng_take(11'h0A0, "R8 head kept");
      reg_read(3'd0, d); check("R10 head kept", d, 11'h030);
   endtask

   task automatic t_abort;
      logic [10:0] d;
      @(negedge clk);
      eng_abort = 1'b1;
      @(negedge clk);
      eng_abort = 1'b0;
      reg_read(3'd6, d); check("R5 tx flushed", d, 0);
      reg_read(3'd7, d); check("R5 rx flushed", d, 0);
      check("R5 cmd_valid low", cmd_valid, 0);
      reg_read(3'd0, d); check("R5 read after flush", d, 0);
   endtask

   task automatic t_enable;
      logic [10:0] d;
      eng_idle = 1'b0;
      reg_write(3'd3, 11'd1);
      check("R6 enable request out", eng_enable, 1);
      repeat (3) @(negedge clk);
      reg_read(3'd4, d); check("R6 status held while busy", d, 0);
      eng_idle = 1'b1;
      @(negedge clk);
      reg_read(3'd4, d); check("R6 status follows at idle", d, 1);
      eng_idle = 1'b0;
      reg_write(3'd3, 11'd0);
      reg_read(3'd4, d); check("R6 disable pending", d, 1);
      eng_idle = 1'b1;
      @(negedge clk);
      reg_read(3'd4, d); check("R6 disable done", d, 0);
   endtask

   task automatic t_status;
      logic [10:0] d;
      eng_active = 1'b1;
      eng_give(8'h55);
      reg_read(3'd5, d); check("R7 active and rx not empty", d, 11'b101);
      eng_active = 1'b0;
      reg_read(3'd0, d); check("R12 byte", d, 11'h055);
      reg_read(3'd5, d); check("R7 idle and empty", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_cmd_order;
      t_tx_thr;
      t_rx_thr;
      t_underflow;
      t_overflows;
      t_abort;
      t_enable;
      t_status;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (R1-all) actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule